// File: doc/BRIEF.md
# Serial-Access Sector Flash Emulator

This block stands in for a small non-volatile byte store of 512 locations held in a synthesizable register array. The store is split into two 256-byte sectors. Nothing reaches the array directly. A 9-bit address register and an 8-bit data register sit in front of it, and each is driven by its own shift clock and its own mode pin. The address register either takes a serial bit or steps forward by one. The data register either takes a serial bit or captures the byte at the current address. The data register's top bit is always visible on a serial output pin.

Two strobes act on the array. A program strobe folds the data register into the addressed byte. Like real flash cells, a program can only pull bits to 0. An erase strobe returns a whole sector to all ones. Both operations take a fixed number of system clock cycles, set by parameters. A busy output is high for that whole time, and strobes that arrive while it is high are dropped.

All control pins are sampled on the system clock `clk`. An event on a control pin is a low-to-high change between two consecutive clock edges.

Top module: `serial_flash_emu`

## Requirements
- R1: The array has 512 bytes with a 9-bit address. Address bit 8 selects the sector: 0 covers 000h-0FFh and 1 covers 100h-1FFh.
- R2: On a rising `addr_clk` with `addr_shift`=1, the address becomes {addr[7:0], `addr_din`}, so bits enter MSB first. With `addr_shift`=0 it becomes addr+1, wrapping from 1FFh to 000h.
- R3: On a rising `data_clk` with `data_shift`=1, the data register becomes {data[6:0], `data_din`}.
- R4: On a rising `data_clk` with `data_shift`=0, the data register loads the byte stored at the current address.
- R5: `data_dout` always equals bit 7 of the data register. A captured byte therefore leaves MSB first as the register is shifted.
- R6: A rising `prog_strobe` while idle captures the address and data registers. When the operation ends, the stored byte becomes old AND data, so bits can only be cleared.
- R7: `busy` rises on the clock edge that accepts a strobe. It stays high for exactly PROG_CYCLES cycles after a program and ERASE_CYCLES cycles after an erase. The array update lands on the edge where `busy` falls.
- R8: A rising `erase_strobe` while idle sets all 256 bytes of the sector named by address bit 8 to FFh. The other sector is left unchanged. If both strobes rise together, program wins.
- R9: A strobe that rises while `busy` is high has no effect on the array or on the length of the running operation.
- R10: After reset the array holds FFh everywhere, the address and data registers are 0, and `busy` is 0.
- R11: A control pin held high for several clocks counts as a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_clk | input | 1 | Address register shift/step clock |
| addr_shift | input | 1 | 1: shift in a bit, 0: increment |
| addr_din | input | 1 | Serial address bit |
| data_clk | input | 1 | Data register clock |
| data_shift | input | 1 | 1: shift in a bit, 0: load from array |
| data_din | input | 1 | Serial data bit |
| prog_strobe | input | 1 | Program request, rising edge |
| erase_strobe | input | 1 | Sector erase request, rising edge |
| data_dout | output | 1 | Data register MSB |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench writes a computed pattern to every one of the 512 locations using auto-increment and reads all of them back. It then increments once more past 1FFh. A wrong wrap would land on a stale location, and a wrong sector boundary would show up in the later erase checks, where one sector must read all FFh while the other keeps its data.

A second program on one byte checks that bits only clear. A design that overwrites instead would return the new byte unchanged.

Strobes are pulsed during a running program to check that they are dropped. A design that accepts them would erase a sector or stretch `busy` past its fixed length.

Holding the address clock high for several cycles must produce a single increment. A level-sensitive design would skip locations.

// File: rtl/serial_flash_emu.sv
module serial_flash_emu #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_clk,
  input  logic addr_shift,
  input  logic addr_din,
  input  logic data_clk,
  input  logic data_shift,
  input  logic data_din,
  input  logic prog_strobe,
  input  logic erase_strobe,
  output logic data_dout,
  output logic busy
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SECTOR  = DEPTH / 2;
  localparam int MAX_LAT = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_q, op_addr;
  logic [DATA_W-1:0] data_q, op_data;
  logic [CNT_W-1:0]  cnt;
  logic              op_erase;
  logic [3:0]        prev;

  wire a_edge = addr_clk     & ~prev[0];
  wire d_edge = data_clk     & ~prev[1];
  wire p_edge = prog_strobe  & ~prev[2];
  wire e_edge = erase_strobe & ~prev[3];
  wire commit = (cnt == CNT_W'(1));

  assign busy      = (cnt != '0);
  assign data_dout = data_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      cnt      <= '0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      prev <= {erase_strobe, prog_strobe, data_clk, addr_clk};

      if (a_edge)
        addr_q <= addr_shift ? {addr_q[ADDR_W-2:0], addr_din} : addr_q + 1'b1;

      if (d_edge)
        data_q <= data_shift ? {data_q[DATA_W-2:0], data_din} : mem[addr_q];

      if (busy) begin
        cnt <= cnt - 1'b1;
      end else if (p_edge) begin
        cnt      <= CNT_W'(PROG_CYCLES);
        op_erase <= 1'b0;
        op_addr  <= addr_q;
        op_data  <= data_q;
      end else if (e_edge) begin
        cnt      <= CNT_W'(ERASE_CYCLES);
        op_erase <= 1'b1;
        op_addr  <= addr_q;
      end

      if (commit) begin
        if (op_erase) begin
          for (int i = 0; i < DEPTH; i++)
            if ((i / SECTOR) == int'(op_addr[ADDR_W-1])) mem[i] <= '1;
        end else begin
          mem[op_addr] <= mem[op_addr] & op_data;
        end
      end
    end
  end
endmodule

module serial_flash_emu_chk #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int CNT_W        = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_clk,
  input logic              addr_shift,
  input logic              data_clk,
  input logic              data_shift,
  input logic              data_din,
  input logic              prog_strobe,
  input logic              erase_strobe,
  input logic              busy,
  input logic              op_erase,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q,
  input logic [CNT_W-1:0]  cnt
);
  logic [3:0]  pv;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv  <= '0;
      run <= '0;
    end else begin
      pv  <= {erase_strobe, prog_strobe, data_clk, addr_clk};
      run <= busy ? run + 16'd1 : 16'd0;
    end
  end

  wire a_e = addr_clk & ~pv[0];
  wire d_e = data_clk & ~pv[1];
  wire s_e = (prog_strobe & ~pv[2]) | (erase_strobe & ~pv[3]);

  assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_e && !addr_shift |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    d_e && data_shift |=> data_q == {$past(data_q[DATA_W-2:0]), $past(data_din)});

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == 16'(op_erase ? ERASE_CYCLES : PROG_CYCLES));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && s_e |=> cnt == CNT_W'($past(cnt) - 1'b1));
endmodule

bind serial_flash_emu serial_flash_emu_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .addr_shift(addr_shift),
  .data_clk(data_clk), .data_shift(data_shift), .data_din(data_din),
  .prog_strobe(prog_strobe), .erase_strobe(erase_strobe), .busy(busy),
  .op_erase(op_erase), .addr_q(addr_q), .data_q(data_q), .cnt(cnt)
);

// File: tb/test_serial_flash_emu.sv
`timescale 1ns/1ps
module test_serial_flash_emu;
  localparam int PL = 3;
  localparam int EL = 5;

  logic clk = 0, rst_n = 0;
  logic addr_clk = 0, addr_shift = 0, addr_din = 0;
  logic data_clk = 0, data_shift = 0, data_din = 0;
  logic prog_strobe = 0, erase_strobe = 0;
  logic data_dout, busy;
  logic [7:0] exp_mem [512];
  int total = 0, bad = 0;

  serial_flash_emu #(.PROG_CYCLES(PL), .ERASE_CYCLES(EL)) i_serial_flash_emu (
    .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .addr_shift(addr_shift),
    .addr_din(addr_din), .data_clk(data_clk), .data_shift(data_shift),
    .data_din(data_din), .prog_strobe(prog_strobe), .erase_strobe(erase_strobe),
    .data_dout(data_dout), .busy(busy));

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic pulse_a(input logic sh, input logic b);
    @(negedge clk); addr_shift = sh; addr_din = b; addr_clk = 1;
    @(negedge clk); addr_clk = 0;
  endtask

  task automatic pulse_d(input logic sh, input logic b);
    @(negedge clk); data_shift = sh; data_din = b; data_clk = 1;
    @(negedge clk); data_clk = 0;
  endtask

  task automatic set_addr(input logic [8:0] a);
    for (int i = 8; i >= 0; i--) pulse_a(1'b1, a[i]);
  endtask

  task automatic load_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) pulse_d(1'b1, v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    pulse_d(1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) begin
      v[i] = data_dout;
      pulse_d(1'b1, 1'b0);
    end
  endtask

  task automatic strobe(input logic is_erase, output int n);
    @(negedge clk);
    if (is_erase) erase_strobe = 1; else prog_strobe = 1;
    n = 0;
    @(negedge clk);
    erase_strobe = 0; prog_strobe = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  logic [7:0] rv;
  int n;

  initial begin
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 busy after reset", busy, 0);
    check("R10 dout after reset", data_dout, 0);

    load_byte(8'h5A);
    strobe(1'b0, n);
    exp_mem[0] &= 8'h5A;
    check("R10 address zero after reset, program length R7", n, PL);
    set_addr(9'h000);
    read_byte(rv);
    check("R10 R6 byte at reset address", rv, exp_mem[0]);

    set_addr(9'h000);
    for (int a = 0; a < 512; a++) begin
      load_byte(pat(a));
      strobe(1'b0, n);
      exp_mem[a] &= pat(a);
      if (a % 64 == 0) check("R7 program busy length", n, PL);
      pulse_a(1'b0, 1'b0);
    end

    set_addr(9'h000);
    for (int a = 0; a < 512; a++) begin
      read_byte(rv);
      check($sformatf("R1 R4 R5 readback at %0h", a), rv, exp_mem[a]);
      pulse_a(1'b0, 1'b0);
    end
    read_byte(rv);
    check("R2 increment wraps 1FF to 000", rv, exp_mem[0]);

    set_addr(9'h010);
    load_byte(8'hF0);
    strobe(1'b0, n);
    exp_mem[9'h010] &= 8'hF0;
    read_byte(rv);
    check("R6 second program only clears bits", rv, exp_mem[9'h010]);

    set_addr(9'h040);
    @(negedge clk); addr_shift = 0; addr_clk = 1;
    repeat (3) @(negedge clk);
    addr_clk = 0;
    read_byte(rv);
    check("R11 held addr clock steps once", rv, exp_mem[9'h041]);

    set_addr(9'h020);
    load_byte(8'h0F);
    @(negedge clk); prog_strobe = 1;
    @(negedge clk); prog_strobe = 0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 1) begin erase_strobe = 1; prog_strobe = 1; end
      if (n == 2) begin erase_strobe = 0; prog_strobe = 0; end
      @(negedge clk);
    end
    exp_mem[9'h020] &= 8'h0F;
    check("R9 busy length with strobes during busy", n, PL);
    repeat (EL + 2) @(negedge clk);
    check("R9 no new operation started", busy, 0);
    read_byte(rv);
    check("R9 programmed byte", rv, exp_mem[9'h020]);
    set_addr(9'h021);
    read_byte(rv);
    check("R9 sector not erased", rv, exp_mem[9'h021]);

    set_addr(9'h1A3);
    strobe(1'b1, n);
    check("R7 erase busy length", n, EL);
    for (int i = 256; i < 512; i++) exp_mem[i] = 8'hFF;
    set_addr(9'h000);
    for (int a = 0; a < 512; a++) begin
      read_byte(rv);
      check($sformatf("R8 after sector 1 erase at %0h", a), rv, exp_mem[a]);
      pulse_a(1'b0, 1'b0);
    end

    set_addr(9'h05C);
    @(negedge clk); erase_strobe = 1; prog_strobe = 1;
    @(negedge clk); erase_strobe = 0; prog_strobe = 0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R8 program wins over simultaneous erase", n, PL);
    exp_mem[9'h05C] &= 8'h00;
    read_byte(rv);
    check("R8 simultaneous strobes programmed byte", rv, exp_mem[9'h05C]);

    set_addr(9'h0FF);
    strobe(1'b1, n);
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    set_addr(9'h0FF);
    read_byte(rv);
    check("R8 sector 0 top erased", rv, 8'hFF);
    pulse_a(1'b0, 1'b0);
    read_byte(rv);
    check("R1 sector boundary 100h", rv, exp_mem[9'h100]);

    load_byte(8'hC3);
    for (int i = 7; i >= 0; i--) begin
      check("R3 R5 shift-out order", data_dout, (8'hC3 >> i) & 1);
      pulse_d(1'b1, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule